// File: doc/BRIEF.md
# Weighted Event Residue Flag

This block samples two single-bit event inputs on every rising clock edge. It does not keep full occurrence counts. It keeps only the residue, modulo 4, of a weighted sum. The first input carries weight two and the second carries weight one. A registered flag is raised whenever that residue equals one.

The residue sits in a small accumulator. On each edge the accumulator adds the weighted contribution of the current inputs and wraps within the modulus. A compare stage turns the next residue into the registered flag. The flag therefore shows the state after the most recent edge. A synchronous active-high reset clears both the residue and the flag.

Top module: `wres_flag_top`

## Requirements
- R1: While `rst` is high at a rising edge, the residue and `hit` become 0 at that edge.
- R2: At each edge where `rst` is low, the residue advances by 2 when `ev_hi` is high and by 1 when `ev_lo` is high. Both contributions are added modulo 4.
- R3: When both inputs are high in one cycle, the residue advances by 3 in a single edge and wraps correctly.
- R4: After each edge, `hit` is 1 exactly when the updated residue equals 1. It is 0 when the residue is 0, 2 or 3.
- R5: After reset, the input pairs (ev_hi, ev_lo) = (0,0), (1,1), (1,0), (0,1) give `hit` = 0, 0, 1, 0 after each successive edge.
- R6: An edge where both inputs are low leaves the residue and `hit` unchanged.
- R7: At any time, `hit` equals 1 exactly when (2·countA + countB) mod 4 = 1. The counts are the edges since the last reset at which each input was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_hi | input | 1 | Event input of weight two |
| ev_lo | input | 1 | Event input of weight one |
| hit | output | 1 | Registered flag, high when the residue is 1 |

## Verification
The residue is never visible at the ports. The hardest case is telling the four residues apart after a wrap, in particular the residue of 3 reached through a single double event. The flag is only high at residue 1, so the bench probes the hidden state with single weight-one steps. From residue 0, one probe raises the flag. From residue 3, two probes are needed. The long random run applies reset at arbitrary points and compares against unbounded reference counts.

// File: rtl/wres_pkg.sv
package wres_pkg;
  localparam int RES_W = 2;
  localparam int HI_WEIGHT = 2;
  localparam int LO_WEIGHT = 1;
  localparam int TARGET = 1;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/wres_accum.sv
module wres_accum
  import wres_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_hi,
  input  logic ev_lo,
  output res_t res_next,
  output res_t res_q
);
  res_t step;

  always_comb begin
    step = '0;
    if (ev_hi) step = step + res_t'(HI_WEIGHT);
    if (ev_lo) step = step + res_t'(LO_WEIGHT);
    res_next = res_q + step;
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_next;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> res_q == '0);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ev_hi && !ev_lo) |=> $stable(res_q));
  a_r3_double_step: assert property (@(posedge clk) disable iff (rst)
    (ev_hi && ev_lo) |=> res_q == res_t'($past(res_q) + 2'd3));
  a_r2_single_lo: assert property (@(posedge clk) disable iff (rst)
    (!ev_hi && ev_lo) |=> res_q == res_t'($past(res_q) + 2'd1));
endmodule

// File: rtl/wres_cmp.sv
module wres_cmp
  import wres_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  res_t res_next,
  output logic hit
);
  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= (res_next == res_t'(TARGET));
  end

  a_r1_flag_low: assert property (@(posedge clk) rst |=> !hit);
endmodule

// File: rtl/wres_flag_top.sv
module wres_flag_top
  import wres_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_hi,
  input  logic ev_lo,
  output logic hit
);
  res_t res_next;
  res_t res_q;

  wres_accum u_acc (
    .clk(clk), .rst(rst), .ev_hi(ev_hi), .ev_lo(ev_lo),
    .res_next(res_next), .res_q(res_q)
  );

  wres_cmp u_cmp (
    .clk(clk), .rst(rst), .res_next(res_next), .hit(hit)
  );

  a_r4_flag_matches: assert property (@(posedge clk) disable iff (rst)
    ##1 (hit == (res_q == res_t'(TARGET))));
endmodule

// File: tb/wres_flag_top_tb_top.sv
module wres_flag_top_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic ev_hi;
  logic ev_lo;
  logic hit;
  int checks = 0;
  int fails = 0;
  int cnt_a = 0;
  int cnt_b = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wres_flag_top dut_i (.clk(clk), .rst(rst), .ev_hi(ev_hi), .ev_lo(ev_lo), .hit(hit));

  function automatic logic ref_hit();
    return ((2*cnt_a + cnt_b) % 4) == 1;
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (hit !== exp) begin
      fails++;
      $display("FAIL %s: hit=%b expected=%b", req, hit, exp);
    end
  endtask

  // One edge: drive at negedge, update the model, sample after the posedge.
  task automatic step(input logic a, input logic b, input logic r);
    @(negedge clk);
    ev_hi = a; ev_lo = b; rst = r;
    @(posedge clk);
    if (r) begin cnt_a = 0; cnt_b = 0; end
    else begin cnt_a += a; cnt_b += b; end
    #1;
  endtask

  task automatic do_reset();
    step(0, 0, 1);
    check("R1", 1'b0);
  endtask

  task automatic t_given_seq();
    logic [1:0] pat [4] = '{2'b00, 2'b11, 2'b10, 2'b01};
    logic exp [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(pat[i][1], pat[i][0], 0);
      check("R5", exp[i]);
    end
  endtask

  task automatic t_double_wrap();
    do_reset();
    step(1, 1, 0);          // residue 3
    check("R3", 1'b0);
    step(0, 1, 0);          // residue 0
    check("R3", 1'b0);
    step(0, 1, 0);          // residue 1
    check("R3", 1'b1);
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0); // 1+9 = 10 mod 4 = 2
    check("R3", 1'b0);
    step(1, 1, 0);          // residue 1
    check("R3", 1'b1);
  endtask

  task automatic t_weights();
    do_reset();
    step(1, 0, 0);          // residue 2
    check("R2", 1'b0);
    step(1, 0, 0);          // residue 0
    check("R2", 1'b0);
    step(0, 1, 0);          // residue 1
    check("R2", 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0);
      check("R6", 1'b1);
    end
    step(1, 0, 0);          // residue 3
    check("R4", 1'b0);
    step(0, 0, 0);
    check("R6", 1'b0);
    step(0, 1, 0);          // residue 0
    check("R4", 1'b0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    step(0, 1, 0);
    check("R4", 1'b1);
    step(1, 1, 1);          // reset overrides inputs
    check("R1", 1'b0);
    step(0, 1, 0);
    check("R1", 1'b1);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic a, b, r;
      a = 1'($urandom);
      b = 1'($urandom);
      r = ($urandom % 50) == 0;
      step(a, b, r);
      check("R7", ref_hit());
    end
  endtask

  initial begin
    rst = 1; ev_hi = 0; ev_lo = 0;
    t_given_seq();
    t_double_wrap();
    t_weights();
    t_reset_mid();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule